// File: doc/BRIEF.md
# Gated Carrier Edge Counter

This block measures the modulation carrier of a received infrared burst. It watches two inputs from the receiver front end: the raw, undemodulated carrier line and the demodulated envelope, which is high while a pulse (mark) is being received. Each rising edge on the carrier line that arrives while the envelope is high adds one to a 16-bit count. Both inputs are asynchronous and are brought into the clock domain by a synchronizer of parameterised depth.

Software controls the counter through a small register port. A control register holds an enable bit and a clear bit. The usual use is to clear and restart the counter at the end of each burst, once the receiver has gone idle: first write clear with enable low, then write enable with clear low. The count is read as two bytes. Reading the low byte captures the high byte at the same moment, so the two reads form one consistent 16-bit value. A result of zero (no carrier seen) and a result of all ones (count out of range) are both invalid measurements. The counter therefore stops at all ones and does not wrap.

Top module: `ir_carrier_counter`

## Requirements
- R1: After reset the count is 0, both control bits are 0 and the read data output is 0.
- R2: The count increases by exactly one for each rising edge of `carrier_in` that occurs while `envelope_in` is high, enable is set and clear is not set. Falling edges, and edges while `envelope_in` is low, leave the count unchanged. An edge is counted SYNC_STAGES+1 clock cycles after the input changes.
- R3: The count saturates at 0xFFFF, the invalid (out of range) code, and holds there for any number of further edges.
- R4: Register address 0 is control. Bit 0 is the enable bit and bit 1 is the clear bit. A write stores both bits. A read returns them in the same positions, with the upper bits read as zero.
- R5: While the clear bit is set, the count is forced to 0 and no edge is counted, even when enable is also set. Clear takes priority over enable. Writing clear and then enable restarts the count from 0.
- R6: While enable is low and clear is low, the count holds its value whatever edges arrive.
- R7: A read of address 1 returns count bits 7:0 and, in the same cycle, captures count bits 15:8 into a shadow register. A read of address 2 returns the shadow, not the live high byte.
- R8: Read data is registered. It changes only in the cycle after `rd_en` is high and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_in | input | 1 | Raw carrier from the IR receiver, asynchronous |
| envelope_in | input | 1 | Demodulated pulse envelope, high during a mark, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
Two functions can fall in the same clock cycle: a counted carrier edge that carries the count from 0x00FF to 0x0100, and a read of the low byte that captures the high byte. The bench drives a single carrier rise and places the low-byte read so that it samples at exactly the edge where the increment lands, taking into account the synchronizer and edge-detect registers. It then expects the low byte 0xFF together with a shadowed high byte of 0x00, and on a later pair of reads the value 0x0100. A second collision, clear and enable set together during active edges, must leave the count at zero.

// File: rtl/ircc_pkg.sv
package ircc_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LO   = 2'd1,
    ADDR_HI   = 2'd2
  } reg_addr_e;

  // bit 1 = clear, bit 0 = enable
  typedef struct packed {
    logic clr;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/ircc_sync.sv
module ircc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d[0] = d;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ircc_front.sv
module ircc_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_in,
  input  logic envelope_in,
  output logic step_o
);
  logic [1:0] raw, synced;
  logic       prev_q;

  assign raw = {envelope_in, carrier_in};

  ircc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced[0];
  end

  assign step_o = synced[0] & ~prev_q & synced[1];
endmodule

// File: rtl/ircc_counter.sv
module ircc_counter
  import ircc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (ctrl_i.clr) begin
      cnt_ce = 1'b1;
      cnt_d  = '0;
    end else if (ctrl_i.en && step_i && cnt_q != SAT) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i.clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.clr && !step_i) |=> $stable(cnt_q));
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SAT && !ctrl_i.clr) |=> cnt_q == SAT);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i.clr |=> cnt_q == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.en && !ctrl_i.clr) |=> $stable(cnt_q));
endmodule

// File: rtl/ircc_regs.sv
module ircc_regs
  import ircc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  count_i,
  output ctrl_t             ctrl_o,
  output logic [BYTE_W-1:0] rd_data
);
  ctrl_t             ctrl_q;
  logic              ctrl_ce;
  logic [BYTE_W-1:0] shadow_q, rdat_q, rdat_d;
  logic              shadow_ce;

  assign ctrl_ce   = wr_en && (wr_addr == ADDR_CTRL);
  assign shadow_ce = rd_en && (rd_addr == ADDR_LO);

  always_comb begin
    rdat_d = '0;
    case (rd_addr)
      ADDR_CTRL: rdat_d = BYTE_W'(ctrl_q);
      ADDR_LO:   rdat_d = count_i[BYTE_W-1:0];
      ADDR_HI:   rdat_d = shadow_q;
      default:   rdat_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      shadow_q <= '0;
      rdat_q   <= '0;
    end else begin
      if (ctrl_ce)   ctrl_q   <= ctrl_t'(wr_data[1:0]);
      if (shadow_ce) shadow_q <= count_i[CNT_W-1:BYTE_W];
      if (rd_en)     rdat_q   <= rdat_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rd_data = rdat_q;

  a_r4_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CTRL) |=> ctrl_q == $past(wr_data[1:0]));
  a_r7_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_LO) |=> shadow_q == $past(count_i[CNT_W-1:BYTE_W]));
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdat_q));
endmodule

// File: rtl/ir_carrier_counter.sv
module ir_carrier_counter
  import ircc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_in,
  input  logic              envelope_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic             step;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] count;

  ircc_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .carrier_in  (carrier_in),
    .envelope_in (envelope_in),
    .step_o      (step)
  );

  ircc_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_i  (ctrl),
    .step_i  (step),
    .count_o (count)
  );

  ircc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .count_i (count),
    .ctrl_o  (ctrl),
    .rd_data (rd_data)
  );
endmodule

// File: tb/test_ir_carrier_counter.sv
module test_ir_carrier_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  typedef struct packed {
    logic        env;
    logic [15:0] n;
    logic [3:0]  hi;
    logic [3:0]  lo;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'd5,   4'd2, 4'd2},
    '{1'b0, 16'd7,   4'd2, 4'd2},
    '{1'b1, 16'd1,   4'd3, 4'd1},
    '{1'b1, 16'd20,  4'd1, 4'd1},
    '{1'b1, 16'd300, 4'd1, 4'd3},
    '{1'b0, 16'd40,  4'd1, 4'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       carrier_in, envelope_in;
  logic       wr_en, rd_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  ir_carrier_counter i_ir_carrier_counter (
    .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .envelope_in(envelope_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic rd16(output int v);
    logic [7:0] l, h;
    rd(2'd1, l);
    rd(2'd2, h);
    v = {h, l};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      carrier_in = 1'b1; idle(hi);
      carrier_in = 1'b0; idle(lo);
    end
  endtask

  task automatic restart();
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    logic [7:0] b;
    rst_n = 1'b0; carrier_in = 1'b0; envelope_in = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    idle(3);
    check("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    idle(2);
    rd(2'd0, b); check("R1 ctrl", int'(b), 0);
    rd16(v);     check("R1 count", v, 0);

    // R2: table walk
    for (int k = 0; k < NV; k++) begin
      restart();
      envelope_in = VECS[k].env;
      idle(3);
      pulses(int'(VECS[k].n), int'(VECS[k].hi), int'(VECS[k].lo));
      idle(5);
      envelope_in = 1'b0;
      idle(4);
      rd16(v);
      check($sformatf("R2 vector %0d", k), v, VECS[k].env ? int'(VECS[k].n) : 0);
    end

    // R4: control readback
    wr(2'd0, 8'hFD);
    rd(2'd0, b); check("R4 ctrl readback", int'(b), 8'h01);

    // R7: low-byte read collides with 0xFF -> 0x100 increment
    restart();
    envelope_in = 1'b1; idle(3);
    pulses(255, 2, 2);
    idle(6);
    @(negedge clk); carrier_in = 1'b1;
    @(negedge clk);
    @(negedge clk); rd_en = 1'b1; rd_addr = 2'd1;
    @(negedge clk); rd_en = 1'b0; b = rd_data;
    check("R7 low byte at collision", int'(b), 8'hFF);
    carrier_in = 1'b0;
    rd(2'd2, b); check("R7 shadow high byte", int'(b), 8'h00);
    idle(4);
    rd16(v); check("R7 coherent after carry", v, 16'h0100);

    // R8: read data holds without rd_en
    pulses(3, 2, 2); idle(6);
    check("R8 rd_data hold", int'(rd_data), 8'h01);

    // R6: enable low holds count
    wr(2'd0, 8'h00);
    pulses(9, 2, 2); idle(6);
    rd16(v); check("R6 hold with enable low", v, 16'h0103);

    // R5: clear and enable together -> clear wins
    wr(2'd0, 8'h03);
    pulses(6, 2, 2); idle(6);
    rd16(v); check("R5 clear priority", v, 0);
    rd(2'd0, b); check("R4 both bits", int'(b), 3);
    wr(2'd0, 8'h01);
    pulses(4, 2, 2); idle(6);
    rd16(v); check("R5 restart count", v, 4);

    // R3: saturation
    restart();
    pulses(65540, 1, 1); idle(6);
    rd16(v); check("R3 saturate", v, 16'hFFFF);
    pulses(3, 1, 1); idle(6);
    rd16(v); check("R3 no wrap", v, 16'hFFFF);
    envelope_in = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule